// File: doc/BRIEF.md
# Capture Sequencer

This block runs the storage side of a sampling capture engine. It decides when encoded samples are written into an external circular RAM and when and how the stored words are played back afterwards. Every sample arrives as a value together with a flag. The flag tells whether the word is a data value or a run-length count word. Once the block is armed, it writes every valid sample at the next RAM address. The write address wraps around the RAM.

In trigger mode the block keeps storing until a trigger pulse arrives, and then stores a programmed number of further samples. In free-run mode the post-trigger phase starts at once on arming. When storing has stopped, the block reads back a programmed number of words, from oldest to newest. The first word read is the one that many addresses behind the stop point. Each word is offered on a valid/ready upload port. The read count may be larger than the number of samples written since arming. In that case the oldest words are left over from an earlier capture, and the block marks them as stale. The oldest real word may be a count word whose value word was overwritten by the wrap. When that happens, the block marks it with a separate qualifier so the consumer can drop it.

Top module: `capture_sequencer`

## Requirements
- R1: After reset, or one cycle after the clear command, the block is idle. `done` and `upValid` are low and no RAM write takes place. The clear command aborts a capture in any state, and a sample presented in the same cycle as the clear is not stored.
- R2: Free-run mode (`useTrig`=0 at arm): starting in the cycle after arm, each valid sample is written to consecutive RAM addresses from address 0. Exactly `delayCount` samples are written, and then writing stops.
- R3: Trigger mode (`useTrig`=1 at arm): every valid sample is written, with the address wrapping modulo the RAM depth, up to and including the trigger cycle. After that, exactly `delayCount` further valid samples are written.
- R4: Read-out starts at the stop address minus the effective read count, modulo the depth, and moves upward one address per word. Each word's bits [DATA_W-1:0] appear on `upData` and its bit DATA_W (1 = count word) appears on `upIsCount`.
- R5: While `upValid` is high and `upReady` is low, `upValid` stays high and `upData` does not change. One word is consumed per cycle in which both are high.
- R6: `done` rises in the cycle after the last word is accepted and stays high until a clear or a new arm. A read count of 0 reaches `done` without uploading any word.
- R7: A read count larger than the RAM depth is treated as exactly the depth.
- R8: If fewer samples were written since arming than the effective read count (N), the first N minus written words uploaded have `upStale` high, and the rest have it low.
- R9: `upOrphan` is high only on the oldest non-stale uploaded word, and only when that word is a count word.
- R10: A trigger outside the trigger wait has no effect, and an arm while a capture or read-out is in progress is ignored.
- R11: In trigger mode with `delayCount`=0, writing stops with the trigger-cycle sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| clearCmd | input | 1 | Synchronous abort back to idle |
| arm | input | 1 | Start a capture from idle or done |
| useTrig | input | 1 | Sampled at arm: 1 waits for a trigger |
| trigger | input | 1 | Trigger pulse from the match logic |
| sampleValid | input | 1 | Sample present this cycle |
| sampleData | input | DATA_W | Encoded sample value |
| sampleIsCount | input | 1 | Sample is a run-length count word |
| delayCount | input | CNT_W | Samples to store after the trigger |
| readCount | input | CNT_W | Words to upload |
| ramWrEn | output | 1 | RAM write strobe |
| ramWrAddr | output | ADDR_W | RAM write address |
| ramWrData | output | DATA_W+1 | {count flag, value} |
| ramRdEn | output | 1 | RAM read strobe (data one cycle later) |
| ramRdAddr | output | ADDR_W | RAM read address |
| ramRdData | input | DATA_W+1 | RAM read data |
| upValid | output | 1 | Upload word valid |
| upReady | input | 1 | Consumer accepts the word |
| upData | output | DATA_W | Uploaded value |
| upIsCount | output | 1 | Uploaded word is a count word |
| upStale | output | 1 | Word predates this capture |
| upOrphan | output | 1 | Oldest real word is a count word |
| done | output | 1 | Read-out finished |

## Verification
The bench aims at the start address of the read-out after the write pointer has wrapped more than a full turn. A design off by one there would upload a shifted window, so every data compare would fail. Read counts above the depth and above the number of samples written are used to expose a missing clamp or a wrong stale boundary: either one shows up as the wrong words flagged, or as stale words let through. Other cases covered are a zero post-trigger delay, a zero read count, gaps in the sample stream, a repeated arm and a mid-capture clear. These catch a sequencer that stores one sample too many or too few, restarts by mistake, or keeps writing after an abort.

// File: rtl/cap_seq_pkg.sv
package cap_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_POST,
    ST_SETUP,
    ST_FETCH,
    ST_LATCH,
    ST_SHOW,
    ST_DONE
  } seqState_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic clearAll;     // restart pointers and fill level
    logic storeSample;  // write the current sample
    logic startRead;    // compute read start and stale count
    logic fetchWord;    // issue RAM read
    logic latchWord;    // capture RAM read data
    logic advanceWord;  // word accepted, move on
  } seqStrobe_t;

endpackage

// File: rtl/capture_seq_ctrl.sv
module capture_seq_ctrl
  import cap_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clearCmd,
  input  logic             arm,
  input  logic             useTrig,
  input  logic             trigger,
  input  logic             sampleValid,
  input  logic [CNT_W-1:0] delayCount,
  input  logic             upReady,
  input  logic             lastWord,
  input  logic             readEmpty,
  output seqStrobe_t       strobe,
  output logic             upValid,
  output logic             done
);

  seqState_e state, stateNext;
  logic [CNT_W-1:0] delayCnt;
  logic armStart;
  logic delayReached;

  assign armStart     = arm && !clearCmd && (state == ST_IDLE || state == ST_DONE);
  assign delayReached = (delayCnt == delayCount);

  always_comb begin
    strobe             = '0;
    strobe.clearAll    = clearCmd || armStart;
    strobe.storeSample = !clearCmd && sampleValid &&
                         (state == ST_PRE || (state == ST_POST && !delayReached));
    strobe.startRead   = !clearCmd && (state == ST_SETUP);
    strobe.fetchWord   = !clearCmd && (state == ST_FETCH);
    strobe.latchWord   = !clearCmd && (state == ST_LATCH);
    strobe.advanceWord = !clearCmd && (state == ST_SHOW) && upReady;
  end

  always_comb begin
    stateNext = state;
    if (clearCmd) begin
      stateNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: if (arm) stateNext = useTrig ? ST_PRE : ST_POST;
        ST_PRE:           if (trigger) stateNext = ST_POST;
        ST_POST:          if (delayReached) stateNext = ST_SETUP;
        ST_SETUP:         stateNext = readEmpty ? ST_DONE : ST_FETCH;
        ST_FETCH:         stateNext = ST_LATCH;
        ST_LATCH:         stateNext = ST_SHOW;
        ST_SHOW:          if (upReady) stateNext = lastWord ? ST_DONE : ST_FETCH;
        default:          stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      delayCnt <= '0;
    end else begin
      state <= stateNext;
      if (armStart || (state == ST_PRE && trigger && !clearCmd))
        delayCnt <= '0;
      else if (strobe.storeSample && state == ST_POST)
        delayCnt <= delayCnt + 1'b1;
    end
  end

  assign upValid = (state == ST_SHOW);
  assign done    = (state == ST_DONE);

  assert_clear_idles_R1: assert property (@(posedge clk) disable iff (!rstN)
    clearCmd |=> (!done && !upValid));

  assert_delay_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_POST) |-> (delayCnt <= delayCount));

  assert_done_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && !clearCmd && !arm) |=> done);

  assert_idle_ignores_trigger_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !arm) |=> (state == ST_IDLE));

endmodule

// File: rtl/capture_seq_datapath.sv
module capture_seq_datapath
  import cap_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              sampleIsCount,
  input  logic [CNT_W-1:0]  readCount,
  output logic              ramWrEn,
  output logic [ADDR_W-1:0] ramWrAddr,
  output logic [DATA_W:0]   ramWrData,
  output logic              ramRdEn,
  output logic [ADDR_W-1:0] ramRdAddr,
  input  logic [DATA_W:0]   ramRdData,
  output logic [DATA_W-1:0] upData,
  output logic              upIsCount,
  output logic              upStale,
  output logic              upOrphan,
  output logic              lastWord,
  output logic              readEmpty
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int FILL_W = ADDR_W + 1;

  logic [ADDR_W-1:0] wrPtr, rdPtr;
  logic [FILL_W-1:0] filled, readEff, readEffReg, staleNum, wordIdx;
  logic [DATA_W-1:0] upDataReg;
  logic upFlagReg, upStaleReg, upOrphanReg;

  // Effective read count: clamp only when the count field can exceed the depth
  generate
    if (CNT_W > ADDR_W) begin : gClamp
      assign readEff = (readCount > CNT_W'(DEPTH)) ? FILL_W'(DEPTH) : FILL_W'(readCount);
    end else begin : gNoClamp
      assign readEff = FILL_W'(readCount);
    end
  endgenerate

  assign readEmpty = (readEff == '0);
  assign lastWord  = (wordIdx == readEffReg - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      filled <= '0;
    end else if (strobe.clearAll) begin
      wrPtr  <= '0;
      filled <= '0;
    end else if (strobe.storeSample) begin
      wrPtr <= wrPtr + 1'b1;
      if (filled != FILL_W'(DEPTH)) filled <= filled + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr      <= '0;
      readEffReg <= '0;
      staleNum   <= '0;
      wordIdx    <= '0;
    end else if (strobe.startRead) begin
      rdPtr      <= wrPtr - readEff[ADDR_W-1:0];
      readEffReg <= readEff;
      staleNum   <= (readEff > filled) ? (readEff - filled) : '0;
      wordIdx    <= '0;
    end else if (strobe.advanceWord) begin
      rdPtr   <= rdPtr + 1'b1;
      wordIdx <= wordIdx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upDataReg   <= '0;
      upFlagReg   <= 1'b0;
      upStaleReg  <= 1'b0;
      upOrphanReg <= 1'b0;
    end else if (strobe.latchWord) begin
      upDataReg   <= ramRdData[DATA_W-1:0];
      upFlagReg   <= ramRdData[DATA_W];
      upStaleReg  <= (wordIdx < staleNum);
      upOrphanReg <= (wordIdx == staleNum) && ramRdData[DATA_W];
    end
  end

  assign ramWrEn   = strobe.storeSample;
  assign ramWrAddr = wrPtr;
  assign ramWrData = {sampleIsCount, sampleData};
  assign ramRdEn   = strobe.fetchWord;
  assign ramRdAddr = rdPtr;
  assign upData    = upDataReg;
  assign upIsCount = upFlagReg;
  assign upStale   = upStaleReg;
  assign upOrphan  = upOrphanReg;

  assert_write_advances_R3: assert property (@(posedge clk) disable iff (!rstN)
    ramWrEn |=> (wrPtr == ADDR_W'($past(wrPtr) + 1'b1)));

  assert_clamped_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startRead |=> (readEffReg <= FILL_W'(DEPTH)));

  assert_fill_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    (filled <= FILL_W'(DEPTH)) && (staleNum <= readEffReg));

endmodule

// File: rtl/capture_sequencer.sv
module capture_sequencer
  import cap_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearCmd,
  input  logic              arm,
  input  logic              useTrig,
  input  logic              trigger,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              sampleIsCount,
  input  logic [CNT_W-1:0]  delayCount,
  input  logic [CNT_W-1:0]  readCount,
  output logic              ramWrEn,
  output logic [ADDR_W-1:0] ramWrAddr,
  output logic [DATA_W:0]   ramWrData,
  output logic              ramRdEn,
  output logic [ADDR_W-1:0] ramRdAddr,
  input  logic [DATA_W:0]   ramRdData,
  output logic              upValid,
  input  logic              upReady,
  output logic [DATA_W-1:0] upData,
  output logic              upIsCount,
  output logic              upStale,
  output logic              upOrphan,
  output logic              done
);

  seqStrobe_t strobe;
  logic lastWord, readEmpty;

  capture_seq_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .clearCmd(clearCmd), .arm(arm), .useTrig(useTrig),
    .trigger(trigger), .sampleValid(sampleValid), .delayCount(delayCount),
    .upReady(upReady), .lastWord(lastWord), .readEmpty(readEmpty),
    .strobe(strobe), .upValid(upValid), .done(done)
  );

  capture_seq_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sampleData(sampleData),
    .sampleIsCount(sampleIsCount), .readCount(readCount),
    .ramWrEn(ramWrEn), .ramWrAddr(ramWrAddr), .ramWrData(ramWrData),
    .ramRdEn(ramRdEn), .ramRdAddr(ramRdAddr), .ramRdData(ramRdData),
    .upData(upData), .upIsCount(upIsCount), .upStale(upStale), .upOrphan(upOrphan),
    .lastWord(lastWord), .readEmpty(readEmpty)
  );

  assert_upload_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (upValid && !upReady && !clearCmd) |=> (upValid && $stable(upData) && $stable(upIsCount)));

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    upValid |-> !(upStale && upOrphan));

endmodule

// File: tb/capture_sequencer_test.sv
module capture_sequencer_test;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 6;
  localparam int CNT_W  = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef struct packed {
    logic       useT;
    logic [7:0] pre;
    logic [7:0] dly;
    logic [7:0] rd;
    logic [7:0] midArm;  // 8'hFF: no extra arm
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'd0,  8'd10, 8'd10,  8'hFF},  // free-run, read == delay
    '{1'b0, 8'd0,  8'd5,  8'd12,  8'hFF},  // read > delay: stale words
    '{1'b0, 8'd0,  8'd12, 8'd4,   8'hFF},  // read < delay: newest 4
    '{1'b1, 8'd70, 8'd6,  8'd20,  8'hFF},  // wrap while waiting
    '{1'b1, 8'd3,  8'd0,  8'd3,   8'hFF},  // zero post-trigger delay
    '{1'b1, 8'd10, 8'd4,  8'd100, 8'hFF},  // read beyond depth
    '{1'b0, 8'd0,  8'd2,  8'd0,   8'hFF},  // zero read count
    '{1'b0, 8'd0,  8'd6,  8'd6,   8'd3}    // repeated arm mid-capture
  };

  logic clk = 1'b0;
  logic rstN, clearCmd, arm, useTrig, trigger, sampleValid, sampleIsCount, upReady;
  logic [DATA_W-1:0] sampleData;
  logic [CNT_W-1:0]  delayCount, readCount;
  logic ramWrEn, ramRdEn, upValid, upIsCount, upStale, upOrphan, done;
  logic [ADDR_W-1:0] ramWrAddr, ramRdAddr;
  logic [DATA_W:0]   ramWrData, ramRdData;
  logic [DATA_W-1:0] upData;

  always #10 clk = ~clk;

  capture_sequencer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .clearCmd(clearCmd), .arm(arm), .useTrig(useTrig),
    .trigger(trigger), .sampleValid(sampleValid), .sampleData(sampleData),
    .sampleIsCount(sampleIsCount), .delayCount(delayCount), .readCount(readCount),
    .ramWrEn(ramWrEn), .ramWrAddr(ramWrAddr), .ramWrData(ramWrData),
    .ramRdEn(ramRdEn), .ramRdAddr(ramRdAddr), .ramRdData(ramRdData),
    .upValid(upValid), .upReady(upReady), .upData(upData), .upIsCount(upIsCount),
    .upStale(upStale), .upOrphan(upOrphan), .done(done)
  );

  // External RAM model, synchronous read
  logic [DATA_W:0] ram [DEPTH];
  int wrSeen = 0;
  initial for (int i = 0; i < DEPTH; i++) ram[i] = '0;
  always @(posedge clk) begin
    if (ramWrEn) begin
      ram[ramWrAddr] <= ramWrData;
      wrSeen <= wrSeen + 1;
    end
    if (ramRdEn) ramRdData <= ram[ramRdAddr];
  end

  // Reference image built from the stimulus only
  logic [DATA_W:0] refMem [DEPTH];
  int refPtr, refFilled;
  logic [DATA_W-1:0] sv = 8'h20;
  int checks = 0;
  int fails = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic refStore(input logic flag, input logic [DATA_W-1:0] val);
    refMem[refPtr % DEPTH] = {flag, val};
    refPtr++;
    if (refFilled < DEPTH) refFilled++;
  endtask

  task automatic runScenario(input bit useT, input int pre, input int dly, input int rd,
                             input int midArm);
    int wr0, stored, k, eff, startA, staleExp, expWr;
    logic [DATA_W:0] expW;
    string tagW;
    delayCount = CNT_W'(dly);
    readCount  = CNT_W'(rd);
    @(negedge clk);
    wr0 = wrSeen;
    useTrig = useT;
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    refPtr = 0;
    refFilled = 0;
    k = 0;
    if (useT) begin
      if (pre == 0) begin
        trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
      end
      for (int i = 0; i < pre; i++) begin
        sampleValid = 1'b1;
        sampleData = sv;
        sampleIsCount = (k % 3 == 0);
        trigger = (i == pre - 1);
        refStore(sampleIsCount, sv);
        sv++;
        k++;
        @(negedge clk);
      end
      sampleValid = 1'b0;
      trigger = 1'b0;
    end
    stored = 0;
    for (int j = 0; j < dly + dly / 3 + 4; j++) begin
      sampleValid = (j % 4 != 2);
      sampleData = sv;
      sampleIsCount = (k % 3 == 0);
      arm = (j == midArm);
      if (sampleValid && stored < dly) begin
        refStore(sampleIsCount, sv);
        stored++;
        k++;
      end
      sv++;
      @(negedge clk);
    end
    sampleValid = 1'b0;
    arm = 1'b0;
    expWr = (useT ? pre : 0) + dly;
    check(useT ? (dly == 0 ? "R11" : "R3") : (midArm >= 0 ? "R10" : "R2"),
          "samples written", wrSeen - wr0, expWr);

    eff = (rd > DEPTH) ? DEPTH : rd;
    startA = (((refPtr - eff) % DEPTH) + DEPTH) % DEPTH;
    staleExp = (eff > refFilled) ? eff - refFilled : 0;
    tagW = (rd > DEPTH) ? "R7" : "R4";
    for (int w = 0; w < eff; w++) begin
      for (int c = 0; c < 40 && !upValid; c++) @(negedge clk);
      expW = refMem[(startA + w) % DEPTH];
      check(tagW, "upload valid", int'(upValid), 1);
      check(tagW, "upload value", int'(upData), int'(expW[DATA_W-1:0]));
      check(tagW, "upload count flag", int'(upIsCount), int'(expW[DATA_W]));
      check("R8", "stale flag", int'(upStale), int'(w < staleExp));
      check("R9", "orphan flag", int'(upOrphan), int'(w == staleExp && expW[DATA_W]));
      if (w % 2 == 0) begin
        @(negedge clk);
        check("R5", "valid held while stalled", int'(upValid), 1);
        check("R5", "value held while stalled", int'(upData), int'(expW[DATA_W-1:0]));
      end
      upReady = 1'b1;
      @(negedge clk);
      upReady = 1'b0;
    end
    for (int c = 0; c < 10 && !done; c++) @(negedge clk);
    check("R6", "done after last word", int'(done), 1);
    check("R6", "no valid after done", int'(upValid), 0);
    @(negedge clk);
    check("R6", "done stays high", int'(done), 1);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int wr0;
    for (int i = 0; i < DEPTH; i++) refMem[i] = '0;
    rstN = 1'b0; clearCmd = 1'b0; arm = 1'b0; useTrig = 1'b0; trigger = 1'b0;
    sampleValid = 1'b0; sampleIsCount = 1'b0; sampleData = '0; upReady = 1'b0;
    delayCount = '0; readCount = '0;
    refPtr = 0; refFilled = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "done after reset", int'(done), 0);
    check("R1", "valid after reset", int'(upValid), 0);
    check("R1", "write after reset", int'(ramWrEn), 0);

    // R10: trigger and samples while idle have no effect
    wr0 = wrSeen;
    for (int i = 0; i < 3; i++) begin
      trigger = 1'b1; sampleValid = 1'b1; sampleData = 8'hAA;
      @(negedge clk);
    end
    trigger = 1'b0; sampleValid = 1'b0;
    @(negedge clk);
    check("R10", "writes while idle", wrSeen - wr0, 0);
    check("R10", "valid while idle", int'(upValid), 0);

    // Main table
    for (int v = 0; v < NVEC; v++)
      runScenario(VECS[v].useT, int'(VECS[v].pre), int'(VECS[v].dly), int'(VECS[v].rd),
                  (VECS[v].midArm == 8'hFF) ? -1 : int'(VECS[v].midArm));

    // R1: clear aborts a capture waiting for its trigger
    delayCount = 8'd4; readCount = 8'd4;
    @(negedge clk);
    wr0 = wrSeen;
    useTrig = 1'b1; arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    refPtr = 0; refFilled = 0;
    for (int i = 0; i < 5; i++) begin
      sampleValid = 1'b1; sampleData = sv; sampleIsCount = 1'b0;
      refStore(1'b0, sv);
      sv++;
      @(negedge clk);
    end
    clearCmd = 1'b1; sampleData = sv;
    @(negedge clk);
    clearCmd = 1'b0;
    check("R1", "done after clear", int'(done), 0);
    check("R1", "valid after clear", int'(upValid), 0);
    for (int i = 0; i < 3; i++) begin
      trigger = 1'b1; sampleData = sv; sv++;
      @(negedge clk);
    end
    trigger = 1'b0; sampleValid = 1'b0;
    repeat (4) @(negedge clk);
    check("R1", "writes around clear", wrSeen - wr0, 5);
    check("R1", "valid stays low after clear", int'(upValid), 0);
    check("R1", "done stays low after clear", int'(done), 0);

    // Recovery after clear
    runScenario(1'b0, 0, 3, 3, -1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule